// File: doc/BRIEF.md
# Synchronous CPU/PCI Clock Divider

This block derives the processor clocks, the bus clocks and a reference clock from a single fast source clock. Two static select inputs pick one of four modes: outputs off (high impedance flagged), a slow processor rate, a fast processor rate, or a test mode. In the test mode the dividers count rising edges of an external test clock instead of source cycles. The source is assumed to run at 200 MHz, so the fast rate is 100 MHz, the slow rate is 66.6 MHz and the bus rate is 33.3 MHz in both active modes.

All outputs come from one shared phase counter. This keeps every bus rising edge on a processor rising edge. Any change of the decoded mode restarts the counter, so a new mode always begins in a known phase. The outputs are plain digital clock levels. A separate flag tells the pad logic when to float them.

Top module: `cdiv_top`

## Requirements
- R1: The mode is decoded from {sel_fast, fs_sel}: 2'b00 off, 2'b01 slow, 2'b10 test, 2'b11 fast. A new code takes effect at the first rising clk edge that samples it.
- R2: In the off mode, out_hiz is 1 and every clock output and ref_out is 0.
- R3: In the fast mode, the processor clocks have a period of 2 source cycles, with 1 cycle high and 1 cycle low.
- R4: In the slow mode, the processor clocks have a period of 3 source cycles, with 1 cycle high followed by 2 cycles low.
- R5: In both active modes, the bus clocks have a period of 6 source cycles, with 3 cycles high. Each bus rising edge occurs in the same cycle as a processor rising edge.
- R6: Both processor outputs are identical. The five gated bus outputs and the free-running bus output are identical.
- R7: In the test mode, one divider step is taken one cycle after each sampled rising edge of test_clk. The processor clocks run at test_clk/2, the bus clocks at test_clk/6, and ref_out carries test_clk delayed by one register.
- R8: In both active modes, ref_out equals xtal_in as sampled at the previous rising clk edge.
- R9: In the cycle after a mode change, the divider phase is 0. In an active or test mode, this means the processor and bus clocks are both high.
- R10: While rst is high, the block returns to the off mode with out_hiz 1 and all clocks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_fast | input | 1 | Upper mode-select bit |
| fs_sel | input | 1 | Lower mode-select bit |
| xtal_in | input | 1 | Crystal-rate clock level to pass through |
| test_clk | input | 1 | External test clock level |
| cpu_clk | output | 2 | Processor clock outputs |
| pci_clk | output | 5 | Bus clock outputs, stoppable group |
| pci_free | output | 1 | Free-running bus clock output |
| ref_out | output | 1 | Reference clock output |
| out_hiz | output | 1 | High when the outputs must float |

## Verification
The divided clocks follow a new select code at the first rising edge that samples it. The reference output follows the crystal or test level one register later. A test-clock rising edge moves the divider two edges after the bench drives it: one edge to sample the level and one edge to detect the rise. The bench changes inputs at the falling edge and samples 2 ns after each rising edge. Its model pushes one expected item per cycle, built with the same edge counting, and the monitor compares that item at the sample point. This makes every comparison fall in the cycle where the result is due.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_SLOW = 2'b01,
        MODE_TEST = 2'b10,
        MODE_FAST = 2'b11
    } cdiv_mode_e;

    typedef struct packed {
        logic cpu;
        logic pci;
    } cdiv_wave_s;

    function automatic cdiv_mode_e decode_mode(input logic sel, input logic fs);
        case ({sel, fs})
            2'b01:   return MODE_SLOW;
            2'b10:   return MODE_TEST;
            2'b11:   return MODE_FAST;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic logic counts_source(input cdiv_mode_e m);
        return (m == MODE_SLOW) || (m == MODE_FAST);
    endfunction

endpackage

// File: rtl/cdiv_mode_ctrl.sv
`timescale 1ns/1ps
module cdiv_mode_ctrl
    import cdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       fs,
    output cdiv_mode_e mode_q,
    output logic       restart
);
    cdiv_mode_e mode_d;

    always_comb begin
        mode_d  = decode_mode(sel, fs);
        restart = (mode_d != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/cdiv_phase_ctr.sv
`timescale 1ns/1ps
module cdiv_phase_ctr #(
    parameter int PCI_DIV = 6,
    localparam int PW = $clog2(PCI_DIV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(PCI_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)   phase <= '0;
        else if (advance)   phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/cdiv_input_path.sv
`timescale 1ns/1ps
module cdiv_input_path (
    input  logic clk,
    input  logic rst,
    input  logic xtal_in,
    input  logic test_clk,
    output logic xtal_q,
    output logic tclk_q,
    output logic tclk_rise
);
    logic tclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            xtal_q    <= 1'b0;
            tclk_q    <= 1'b0;
            tclk_prev <= 1'b0;
        end else begin
            xtal_q    <= xtal_in;
            tclk_q    <= test_clk;
            tclk_prev <= tclk_q;
        end
    end

    assign tclk_rise = tclk_q & ~tclk_prev;
endmodule

// File: rtl/cdiv_wave.sv
`timescale 1ns/1ps
module cdiv_wave
    import cdiv_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 3,
    parameter int PCI_DIV  = 6,
    localparam int PW = $clog2(PCI_DIV)
) (
    input  cdiv_mode_e    mode,
    input  logic [PW-1:0] phase,
    output cdiv_wave_s    wave
);
    localparam int PCI_HIGH = PCI_DIV / 2;

    always_comb begin
        wave = '0;
        case (mode)
            MODE_FAST, MODE_TEST: begin
                wave.cpu = ((32'(phase) % FAST_DIV) == 0);
                wave.pci = (32'(phase) < PCI_HIGH);
            end
            MODE_SLOW: begin
                wave.cpu = ((32'(phase) % SLOW_DIV) == 0);
                wave.pci = (32'(phase) < PCI_HIGH);
            end
            default: wave = '0;
        endcase
    end
endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int NUM_CPU  = 2,
    parameter int NUM_PCI  = 5,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 3,
    parameter int PCI_DIV  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_fast,
    input  logic               fs_sel,
    input  logic               xtal_in,
    input  logic               test_clk,
    output logic [NUM_CPU-1:0] cpu_clk,
    output logic [NUM_PCI-1:0] pci_clk,
    output logic               pci_free,
    output logic               ref_out,
    output logic               out_hiz
);
    localparam int PW = $clog2(PCI_DIV);

    cdiv_mode_e    mode_q;
    logic          restart;
    logic          xtal_q, tclk_q, tclk_rise;
    logic          ctr_clear, ctr_adv;
    logic [PW-1:0] phase;
    cdiv_wave_s    wave;

    cdiv_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .sel(sel_fast), .fs(fs_sel),
        .mode_q(mode_q), .restart(restart)
    );

    cdiv_input_path u_in (
        .clk(clk), .rst(rst), .xtal_in(xtal_in), .test_clk(test_clk),
        .xtal_q(xtal_q), .tclk_q(tclk_q), .tclk_rise(tclk_rise)
    );

    always_comb begin
        ctr_clear = restart || (mode_q == MODE_OFF);
        ctr_adv   = counts_source(mode_q) || ((mode_q == MODE_TEST) && tclk_rise);
    end

    cdiv_phase_ctr #(.PCI_DIV(PCI_DIV)) u_ctr (
        .clk(clk), .rst(rst), .clear(ctr_clear), .advance(ctr_adv), .phase(phase)
    );

    cdiv_wave #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .PCI_DIV(PCI_DIV)) u_wave (
        .mode(mode_q), .phase(phase), .wave(wave)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        assign cpu_clk[i] = wave.cpu;
    end

    for (genvar j = 0; j < NUM_PCI; j++) begin : g_pci
        assign pci_clk[j] = wave.pci;
    end

    assign pci_free = wave.pci;
    assign out_hiz  = (mode_q == MODE_OFF);

    always_comb begin
        case (mode_q)
            MODE_TEST:            ref_out = tclk_q;
            MODE_SLOW, MODE_FAST: ref_out = xtal_q;
            default:              ref_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdiv_checker.sv
`timescale 1ns/1ps
module cdiv_checker
    import cdiv_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_PCI = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               sel_fast,
    input logic               fs_sel,
    input cdiv_mode_e         mode_q,
    input logic [NUM_CPU-1:0] cpu_clk,
    input logic [NUM_PCI-1:0] pci_clk,
    input logic               pci_free,
    input logic               ref_out,
    input logic               out_hiz
);
    p_reset_off_r10: assert property (@(posedge clk) rst |=> out_hiz);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        out_hiz |-> (cpu_clk == '0 && pci_clk == '0 && !pci_free && !ref_out));

    p_cpu_same_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_clk == {NUM_CPU{cpu_clk[0]}});

    p_pci_same_r6: assert property (@(posedge clk) disable iff (rst)
        pci_clk == {NUM_PCI{pci_free}});

    p_pci_edge_align_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pci_free) |-> cpu_clk[0]);

    p_fast_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FAST && {sel_fast, fs_sel} == 2'b11) |=> (cpu_clk[0] != $past(cpu_clk[0])));

    p_slow_single_high_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLOW && {sel_fast, fs_sel} == 2'b01 && cpu_clk[0]) |=> !cpu_clk[0]);

    p_restart_phase_r9: assert property (@(posedge clk) disable iff (rst)
        ({sel_fast, fs_sel} != mode_q && {sel_fast, fs_sel} != 2'b00) |=> (cpu_clk[0] && pci_free));
endmodule

bind cdiv_top cdiv_checker #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) u_chk (
    .clk(clk), .rst(rst), .sel_fast(sel_fast), .fs_sel(fs_sel), .mode_q(mode_q),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free(pci_free),
    .ref_out(ref_out), .out_hiz(out_hiz)
);

// File: tb/tb_cdiv_top.sv
`timescale 1ns/1ps
module tb_cdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_fast = 1'b0, fs_sel = 1'b0, xtal_in = 1'b0, test_clk = 1'b0;
    logic [1:0] cpu_clk;
    logic [4:0] pci_clk;
    logic       pci_free, ref_out, out_hiz;

    cdiv_top dut (
        .clk(clk), .rst(rst), .sel_fast(sel_fast), .fs_sel(fs_sel),
        .xtal_in(xtal_in), .test_clk(test_clk), .cpu_clk(cpu_clk),
        .pci_clk(pci_clk), .pci_free(pci_free), .ref_out(ref_out), .out_hiz(out_hiz)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic  cpu;
        logic  pci;
        logic  refc;
        logic  hiz;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    int   n = 0;
    int   cyc = 0;
    logic [1:0] mprev = 2'b00;
    logic t1 = 1'b0, t2 = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus plus one expected item
    task automatic step(input logic [1:0] code, input logic tclk);
        exp_t e;
        logic x;
        bit   changed;
        @(negedge clk);
        x = cyc[0] ^ cyc[2];
        cyc++;
        {sel_fast, fs_sel} = code;
        xtal_in  = x;
        test_clk = tclk;
        changed  = (code != mprev);
        if (changed || code == 2'b00)                 n = 0;
        else if (code == 2'b01 || code == 2'b11)      n = (n + 1) % 6;
        else if (code == 2'b10 && t1 && !t2)          n = (n + 1) % 6;
        t2 = t1;
        t1 = tclk;
        mprev = code;
        e.hiz = (code == 2'b00);
        e.pci = (code != 2'b00) && (n < 3);
        case (code)
            2'b11: begin e.cpu = (n % 2 == 0); e.refc = x;    e.tag = "R3"; end
            2'b01: begin e.cpu = (n % 3 == 0); e.refc = x;    e.tag = "R4"; end
            2'b10: begin e.cpu = (n % 2 == 0); e.refc = tclk; e.tag = "R7"; end
            default: begin e.cpu = 1'b0;       e.refc = 1'b0; e.tag = "R2"; end
        endcase
        if (changed && code != 2'b00) e.tag = "R9";
        q.push_back(e);
    endtask

    task automatic run(input logic [1:0] code, input int cycles, input int thalf);
        for (int k = 0; k < cycles; k++)
            step(code, (thalf == 0) ? 1'b0 : logic'((k / thalf) % 2));
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(out_hiz == e.hiz, {e.tag, "/R1 hiz"}, out_hiz, e.hiz);
                check(cpu_clk[0] == e.cpu, {e.tag, " cpu"}, cpu_clk[0], e.cpu);
                check(pci_free == e.pci, {e.tag, "/R5 pci"}, pci_free, e.pci);
                check(ref_out == e.refc, (e.tag == "R7") ? "R7 ref" : "R8 ref", ref_out, e.refc);
                check(cpu_clk == {2{cpu_clk[0]}} && pci_clk == {5{pci_free}}, "R6 copies",
                      {pci_clk, cpu_clk}, {{5{pci_free}}, {2{cpu_clk[0]}}});
            end
        end
    end

    bit done = 0;
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        {sel_fast, fs_sel} = 2'b11;
        repeat (4) @(negedge clk);
        check(out_hiz == 1'b1, "R10 hiz in reset", out_hiz, 1);
        check(cpu_clk == 2'b00 && pci_clk == 5'b0 && !pci_free && !ref_out, "R10 clocks low",
              {cpu_clk, pci_clk, pci_free, ref_out}, 0);
        {sel_fast, fs_sel} = 2'b00;
        @(negedge clk);
        rst = 1'b0;
        run(2'b00, 6, 0);
        run(2'b11, 20, 0);
        run(2'b01, 24, 0);
        run(2'b11, 7, 0);
        run(2'b01, 10, 0);
        run(2'b00, 4, 0);
        run(2'b10, 60, 2);
        run(2'b10, 30, 1);
        run(2'b11, 5, 0);
        run(2'b10, 40, 3);
        run(2'b01, 8, 0);
        run(2'b00, 4, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule